// File: doc/BRIEF.md
# UART Receive Queue with Interrupt Conditions

This block is the receive-side buffer of a UART. The character deserializer upstream presents each finished character together with its break, parity and framing flags on a one-cycle strobe. The block stores the character and its flags as one entry in a 16-deep queue. A baud-rate divider outside the block supplies a one-cycle pulse once per character time.

Software reaches the block through a small word-wide register port. Reading the data register removes the oldest entry. A second register holds the interrupt enables and the live interrupt conditions. A third register holds the receive enable, the fill threshold, the idle timeout in character times and a self-clearing queue flush bit.

Three conditions can raise the interrupt line, each with its own enable:
- a character was lost because the queue was full;
- the queue holds more entries than the threshold;
- the queue has data but has seen no traffic for the programmed number of character times.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the queue is empty, all interrupt enables and conditions are 0, the interrupt line is low, and the control register reads 0x0810. That value is receive disabled (bit 0), timeout 1 (bits [7:4]) and threshold 8 (bits [12:8]).
- R2: A read of the data register (address 0) returns the oldest entry: the character in bits [7:0], a valid flag in bit 8, break in bit 9, parity error in bit 10 and framing error in bit 11. A valid read removes that entry. Entries come out in arrival order.
- R3: A read of the data register while the queue is empty returns 0 with valid clear, and changes nothing.
- R4: A character strobed in while the receive enable (control bit 0) is clear is not stored.
- R5: A character that arrives while 16 entries are held is discarded and sets the overrun condition (interrupt register bit 8). The 16 stored entries come out unchanged.
- R6: The overrun condition stays set while the queue is drained. Only a write of 1 to the flush bit (control bit 1) clears it.
- R7: Writing the flush bit empties the queue in one cycle and clears the timeout condition. The flush bit always reads back as 0.
- R8: The threshold condition (interrupt register bit 9) is 1 exactly when the number of held entries is greater than the threshold field.
- R9: The timeout condition (interrupt register bit 10) sets once the queue is non-empty and the programmed number of character-time pulses has passed with no store or removal. Every store or removal restarts the count. It never sets while the queue is empty, and a field value of 0 disables it.
- R10: The not-empty flag (interrupt register bit 11) mirrors whether the queue holds any entry.
- R11: The interrupt register's bits [2:0] are write/read enables for overrun, threshold and timeout. The interrupt output is high exactly when a condition is set and its enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_stb | input | 1 | One-cycle strobe: a received character is present |
| rx_char | input | 8 | Received character |
| rx_brk | input | 1 | Break detected on this character |
| rx_par | input | 1 | Parity error on this character |
| rx_frm | input | 1 | Framing error on this character |
| char_tick | input | 1 | One pulse per character time |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 data, 1 interrupt, 2 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Interrupt request |

## Verification
A wrong fill count or pointer shows at the ports on the next data read: an entry comes out of order, a stale entry appears, or the valid flag is wrong. The threshold and not-empty bits also show it, one cycle after the store or removal that went wrong. A lost overrun flag, or one that was cleared when it should not be, shows in the interrupt register on the very next read. A timer that restarts at the wrong moment shifts the timeout bit by whole character pulses, and the bench compares that bit against the pulse it counted itself.

// File: rtl/rxq_pkg.sv
// Shared types and register map constants for the UART receive queue.
package rxq_pkg;
    localparam int CHAR_W = 8;

    // One stored entry: flags beside the character.
    typedef struct packed {
        logic              frm;
        logic              par;
        logic              brk;
        logic [CHAR_W-1:0] ch;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    // Register addresses.
    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_IRQ  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    // Interrupt condition indices.
    localparam int IDX_OVR = 0;
    localparam int IDX_THR = 1;
    localparam int IDX_TMO = 2;
    localparam int N_COND  = 3;
endpackage

// File: rtl/rxq_fifo.sv
// Entry storage: a circular buffer of DEPTH entries with a fill count.
// Assumes DEPTH is a power of two. A push while full and a pop while
// empty are ignored. A clear empties the buffer and wins over push and pop.
module rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 11,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign rdata   = mem[rp];

    // Write the incoming entry into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    // Move the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/rxq_timer.sv
// Idle timer counted in character-time pulses. The count restarts on any
// queue activity and holds at zero while the queue is empty. The timer
// fires when the count reaches a non-zero limit and the queue has data.
module rxq_timer #(
    parameter int TO_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            empty,
    input  logic            tick,
    input  logic [TO_W-1:0] limit,
    output logic            fired
);
    logic [TO_W-1:0] idle;

    // Count character times since the last activity, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || empty) idle <= '0;
        else if (tick && idle != limit)  idle <= idle + 1'b1;
    end

    assign fired = (limit != '0) && (idle == limit) && !empty;
endmodule

// File: rtl/rxq_irq.sv
// Interrupt conditions and enables. Overrun is sticky until a flush;
// threshold and timeout follow their live inputs. The request is the OR
// of the enabled conditions.
module rxq_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         ovr_evt,
    input  logic         thr_hit,
    input  logic         tmo_hit,
    input  logic         en_we,
    input  logic [N-1:0] en_wd,
    output logic [N-1:0] cond,
    output logic [N-1:0] en,
    output logic         irq
);
    import rxq_pkg::*;
    logic ovr_q;

    // Hold the overrun flag until a flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) ovr_q <= 1'b0;
        else if (ovr_evt)    ovr_q <= 1'b1;
    end

    // Software-written interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (en_we) en <= en_wd;
    end

    // Gather the conditions in their fixed bit order.
    always_comb begin
        cond          = '0;
        cond[IDX_OVR] = ovr_q;
        cond[IDX_THR] = thr_hit;
        cond[IDX_TMO] = tmo_hit;
    end

    assign irq = |(cond & en);
endmodule

// File: rtl/uart_rx_queue.sv
// UART receive queue top. It decodes the register port, holds the control
// fields and ties storage, timer and interrupt logic together. It assumes
// rx_stb and char_tick are single-cycle pulses in this clock domain.
module uart_rx_queue #(
    parameter int DEPTH   = 16,
    parameter int TO_W    = 4,
    parameter int THR_RST = DEPTH / 2,
    parameter int TO_RST  = 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_stb,
    input  logic [7:0]  rx_char,
    input  logic        rx_brk,
    input  logic        rx_par,
    input  logic        rx_frm,
    input  logic        char_tick,
    input  logic        reg_sel,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    import rxq_pkg::*;

    localparam int TO_LSB  = 4;
    localparam int THR_LSB = 8;

    logic              rx_en;
    logic [CW-1:0]     thr;
    logic [TO_W-1:0]   tmo_lim;
    logic              wr_ctrl, wr_irq, rd_data, flush;
    logic              push_req, ovr_evt, pop_req;
    rx_entry_t         in_ent, head;
    logic [CW-1:0]     count;
    logic              empty, full, tmo_hit;
    logic [N_COND-1:0] cond, en;

    assign wr_ctrl  = reg_sel && reg_wr && reg_addr == ADDR_CTRL;
    assign wr_irq   = reg_sel && reg_wr && reg_addr == ADDR_IRQ;
    assign rd_data  = reg_sel && !reg_wr && reg_addr == ADDR_DATA;
    assign flush    = wr_ctrl && reg_wdata[1];
    assign push_req = rx_stb && rx_en && !flush;
    assign ovr_evt  = push_req && full;
    assign pop_req  = rd_data && !empty;

    // Pack the incoming character with its flags.
    always_comb begin
        in_ent.ch  = rx_char;
        in_ent.brk = rx_brk;
        in_ent.par = rx_par;
        in_ent.frm = rx_frm;
    end

    // Control fields: receive enable, timeout limit, threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en   <= 1'b0;
            tmo_lim <= TO_W'(TO_RST);
            thr     <= CW'(THR_RST);
        end else if (wr_ctrl) begin
            rx_en   <= reg_wdata[0];
            tmo_lim <= reg_wdata[TO_LSB +: TO_W];
            thr     <= reg_wdata[THR_LSB +: CW];
        end
    end

    rxq_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .push(push_req), .wdata(in_ent),
        .pop(pop_req), .rdata(head),
        .count(count), .empty(empty), .full(full)
    );

    rxq_timer #(.TO_W(TO_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .restart(flush || pop_req || (push_req && !full)),
        .empty(empty), .tick(char_tick), .limit(tmo_lim),
        .fired(tmo_hit)
    );

    rxq_irq #(.N(N_COND)) u_irq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ovr_evt(ovr_evt), .thr_hit(count > thr), .tmo_hit(tmo_hit),
        .en_we(wr_irq), .en_wd(reg_wdata[N_COND-1:0]),
        .cond(cond), .en(en), .irq(irq)
    );

    // Read multiplexer for the register port.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_DATA: if (!empty) reg_rdata[11:0] = {head.frm, head.par, head.brk, 1'b1, head.ch};
            ADDR_IRQ: begin
                reg_rdata[N_COND-1:0] = en;
                reg_rdata[8 +: N_COND] = cond;
                reg_rdata[11]          = !empty;
            end
            ADDR_CTRL: begin
                reg_rdata[0]                = rx_en;
                reg_rdata[TO_LSB +: TO_W]   = tmo_lim;
                reg_rdata[THR_LSB +: CW]    = thr;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_rx_queue_chk.sv
// Property checker for the receive queue, bound to every instance of the top.
module uart_rx_queue_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          pop_req,
    input logic          push_req,
    input logic          full,
    input logic          empty,
    input logic [CW-1:0] count,
    input logic [2:0]    cond
);
    // R5: a full queue with no removal stays at full depth.
    a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop_req && !flush |=> full);
    // R6: overrun persists until a flush.
    a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cond[0] && !flush |=> cond[0]);
    // R7: a flush leaves the queue empty and the overrun clear.
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty && !cond[0] && !cond[2]);
    // R9: no timeout while empty.
    a_r9_no_tmo_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !cond[2]);
    // R2: the fill count never exceeds the depth.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R9: a store restarts the idle time, so no timeout just after a store.
    a_r9_push_restart: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && !full && !flush |=> !cond[2]);
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pop_req(pop_req),
    .push_req(push_req), .full(full), .empty(empty), .count(count),
    .cond(cond)
);

// File: tb/uart_rx_queue_test.sv
// Scoreboard bench: stored characters are queued on send, compared on read.
module uart_rx_queue_test;
    logic        clk = 0, rst_n = 0;
    logic        rx_stb = 0, rx_brk = 0, rx_par = 0, rx_frm = 0, char_tick = 0;
    logic [7:0]  rx_char = 0;
    logic        reg_sel = 0, reg_wr = 0;
    logic [1:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        irq;
    int          n_cmp = 0, n_bad = 0;
    logic [11:0] exp_q[$];
    logic [31:0] rd;
    bit          done = 0;

    always #4 clk = ~clk;

    uart_rx_queue uut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [1:0] a, logic [31:0] d);
        @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_sel = 0; reg_wr = 0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_sel = 1; reg_wr = 0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_sel = 0;
    endtask

    // Driver: strobe one character; queue it when it should be stored.
    task automatic send(logic [7:0] c, logic b, logic p, logic f, bit stored);
        @(negedge clk); rx_stb = 1; rx_char = c; rx_brk = b; rx_par = p; rx_frm = f;
        @(negedge clk); rx_stb = 0;
        if (stored) exp_q.push_back({f, p, b, 1'b1, c});
    endtask

    // Monitor: read the data port and compare with the scoreboard head.
    task automatic pop_check(string req);
        logic [11:0] e;
        rd_reg(2'd0, rd);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 12'h000;
        check(req, rd, {20'h0, e});
    endtask

    task automatic tick();
        @(negedge clk); char_tick = 1;
        @(negedge clk); char_tick = 0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_reg(2'd2, rd); check("R1 ctrl", rd, 32'h0810);
        rd_reg(2'd1, rd); check("R1 irq reg", rd, 32'h0);
        check("R1 irq pin", irq, 0);
        // R4 disabled receive
        send(8'h41, 0, 0, 0, 0);
        rd_reg(2'd1, rd); check("R4 not stored", rd[11], 0);
        wr_reg(2'd2, 32'h0811);
        // R2 order and flag layout
        send(8'h12, 1, 0, 0, 1);
        send(8'h34, 0, 1, 0, 1);
        send(8'h56, 0, 0, 1, 1);
        rd_reg(2'd1, rd); check("R10 not-empty", rd[11], 1);
        pop_check("R2 entry0"); pop_check("R2 entry1"); pop_check("R2 entry2");
        rd_reg(2'd1, rd); check("R10 empty", rd[11], 0);
        // R3 empty read
        pop_check("R3 empty read");
        // R8 threshold = 8
        wr_reg(2'd1, 32'h2);
        for (int i = 0; i < 8; i++) send(8'(i), 0, 0, 0, 1);
        rd_reg(2'd1, rd); check("R8 at thr", rd[9], 0);
        check("R11 irq low", irq, 0);
        send(8'h88, 0, 0, 0, 1);
        rd_reg(2'd1, rd); check("R8 above thr", rd[9], 1);
        check("R11 irq thr", irq, 1);
        wr_reg(2'd1, 32'h0);
        check("R11 masked", irq, 0);
        // R5 overrun: fill to 16 then one extra
        for (int i = 0; i < 7; i++) send(8'hA0 + 8'(i), i[0], 0, 0, 1);
        send(8'hEE, 0, 0, 0, 0);
        rd_reg(2'd1, rd); check("R5 overrun set", rd[8], 1);
        for (int i = 0; i < 16; i++) pop_check("R5 contents");
        pop_check("R5 extra dropped");
        // R6 sticky after drain
        rd_reg(2'd1, rd); check("R6 still set", rd[8], 1);
        wr_reg(2'd1, 32'h1);
        check("R11 irq ovr", irq, 1);
        wr_reg(2'd2, 32'h0813);
        rd_reg(2'd1, rd); check("R6 cleared by flush", rd[8], 0);
        check("R11 irq after flush", irq, 0);
        rd_reg(2'd2, rd); check("R7 flush reads 0", rd, 32'h0811);
        // R7 flush empties queue
        send(8'h01, 0, 0, 0, 0); send(8'h02, 0, 0, 0, 0);
        wr_reg(2'd2, 32'h0813);
        rd_reg(2'd1, rd); check("R7 empty", rd[11], 0);
        pop_check("R7 no data");
        // R9 timeout of 1
        wr_reg(2'd1, 32'h4);
        tick();
        rd_reg(2'd1, rd); check("R9 no tmo empty", rd[10], 0);
        send(8'h77, 0, 0, 0, 1);
        rd_reg(2'd1, rd); check("R9 before tick", rd[10], 0);
        tick();
        rd_reg(2'd1, rd); check("R9 after 1 tick", rd[10], 1);
        check("R11 irq tmo", irq, 1);
        send(8'h78, 0, 0, 0, 1);
        rd_reg(2'd1, rd); check("R9 push restarts", rd[10], 0);
        // R9 timeout of 3
        wr_reg(2'd2, 32'h0831);
        tick(); tick();
        rd_reg(2'd1, rd); check("R9 2 of 3", rd[10], 0);
        tick();
        rd_reg(2'd1, rd); check("R9 3 of 3", rd[10], 1);
        pop_check("R9 data");
        rd_reg(2'd1, rd); check("R9 pop restarts", rd[10], 0);
        // R9 zero disables
        wr_reg(2'd2, 32'h0801);
        tick(); tick();
        rd_reg(2'd1, rd); check("R9 zero limit", rd[10], 0);
        pop_check("R2 last");
        done = 1;
        finish_run();
    end
endmodule